// File: doc/BRIEF.md
# True Dual-Port Block RAM

This block is a synthesizable true dual-port memory built like an embedded FPGA RAM tile. Two fully independent ports, A and B, each own a clock, a clock enable, a write enable, a 3-bit chip select, a local output reset, an address, write data and read data. A port takes part in an access only when its clock enable is high and its chip select equals that port's match parameter. Several tiles can therefore share address and data wiring, with each tile answering only to its own slice of a deeper memory.

Each port has an output latch. Its contents on a write cycle depend on the port's write mode parameter: the latch holds, shows the new data, or shows the word that was overwritten. An optional output register adds one cycle of latency. Each port's local reset clears that port's output stage, and an active-low global reset clears both ports. A parameter selects whether these resets act asynchronously or on the port's clock edge. Reset never changes the stored words.

When both ports write one address in the same cycle, the stored word is undefined. Users must avoid this case, and it is not checked.

Top module: `tdp_block_ram`

## Requirements
- R1: Address, data and controls are sampled on the port's rising clock edge. A read (port selected, write enable 0) loads the addressed word into the output latch at that edge.
- R2: With the port's output-register parameter set to 1, `dout` shows the latch value one edge later. The output register loads at every edge where the port's clock enable is 1. With the parameter at 0, `dout` is the latch itself.
- R3: In hold write mode (encoding 0), a write cycle stores the data and leaves the port's output latch unchanged.
- R4: In pass-through write mode (encoding 1), a write cycle stores the data and loads the same data into the port's output latch.
- R5: In old-data write mode (encoding 2), a write cycle stores the new data and loads the word previously held at that address into the port's output latch.
- R6: A port is selected only when its clock enable is 1 and its 3-bit chip select equals its match parameter. An unselected port stores nothing and its output latch holds.
- R7: A high level on a port's local reset clears only that port's latch and output register to zero. With the async-reset parameter at 1 this happens at once; with it at 0 it happens at the next edge of that port's clock. Stored words are unaffected.
- R8: A low level on the global reset clears the output stages of both ports, with the same timing choice as R7. Stored words are unaffected.
- R9: A read on one port of an address that the other port writes in the same cycle returns the old word. Writes from the two ports to different addresses in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| ce_a | input | 1 | Port A clock enable |
| we_a | input | 1 | Port A write enable |
| cs_a | input | 3 | Port A chip select, compared with CS_MATCH_A |
| rst_a | input | 1 | Port A output reset, active high |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| dout_a | output | DATA_W | Port A read data |
| clk_b | input | 1 | Port B clock |
| ce_b | input | 1 | Port B clock enable |
| we_b | input | 1 | Port B write enable |
| cs_b | input | 3 | Port B chip select, compared with CS_MATCH_B |
| rst_b | input | 1 | Port B output reset, active high |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| dout_b | output | DATA_W | Port B read data |
| gsr_n | input | 1 | Global output reset for both ports, active low |

## Verification
The bench builds three copies with a 4-bit address and 8-bit data, chip-select matches 5 and 2, and a shared clock. This size lets every address be written and read back from either port within a short sweep. The copies together place hold, pass-through and old-data mode on each port, and give each port both output-register settings. One copy uses asynchronous resets, so a reset raised mid-cycle can be compared against a copy with synchronous resets before the next edge arrives. All copies receive the same stimulus, so a single reference array predicts the stored contents for all of them.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;

  // Output behaviour of a port on its own write cycle
  typedef enum logic [1:0] {
    WM_HOLD = 2'd0,   // latch keeps its value (R3)
    WM_PASS = 2'd1,   // latch takes the write data (R4)
    WM_OLD  = 2'd2    // latch takes the overwritten word (R5)
  } wmode_e;

  localparam int CS_W = 3;

  // A port takes part in an access only when enabled and addressed (R6)
  function automatic logic port_hit(input logic ce,
                                    input logic [CS_W-1:0] cs,
                                    input logic [CS_W-1:0] match);
    return ce && (cs == match);
  endfunction

endpackage

// File: rtl/tdp_ram_bank.sv
// One storage bank, written by a single port, read at both port addresses.
module tdp_ram_bank #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wword,
  input  logic [ADDR_W-1:0] raddr0,
  input  logic [ADDR_W-1:0] raddr1,
  output logic [DATA_W-1:0] rdata0,
  output logic [DATA_W-1:0] rdata1
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Power-up contents are zero, like an unconfigured embedded RAM
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wword;
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];

endmodule

// File: rtl/tdp_ram_port.sv
// Port control: selection, output latch per write mode, optional output register.
module tdp_ram_port
  import tdp_ram_pkg::*;
#(
  parameter int            DATA_W    = 18,
  parameter wmode_e        MODE      = WM_HOLD,
  parameter bit            OUT_REG   = 1'b0,
  parameter bit            RST_ASYNC = 1'b0,
  parameter logic [CS_W-1:0] CS_MATCH = '0
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              we,
  input  logic [CS_W-1:0]   cs,
  input  logic              rst,
  input  logic              gsr_n,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rd_word,
  output logic              hit,
  output logic              wr_fire,
  output logic [DATA_W-1:0] lat_q,
  output logic [DATA_W-1:0] dout
);

  // Next latch value for one access, chosen by write mode (R1, R3, R4, R5)
  function automatic logic [DATA_W-1:0] latch_next(input logic sel,
                                                   input logic wr,
                                                   input logic [DATA_W-1:0] wdata,
                                                   input logic [DATA_W-1:0] old,
                                                   input logic [DATA_W-1:0] cur);
    if (!sel) return cur;
    if (!wr)  return old;
    case (MODE)
      WM_PASS: return wdata;
      WM_OLD:  return old;
      default: return cur;
    endcase
  endfunction

  logic              clr;
  logic [DATA_W-1:0] lat_nxt;

  assign hit     = port_hit(ce, cs, CS_MATCH);
  assign wr_fire = hit && we;
  assign clr     = rst || !gsr_n;
  assign lat_nxt = latch_next(hit, we, din, rd_word, lat_q);

  generate
    if (RST_ASYNC) begin : g_lat_async
      always_ff @(posedge clk or posedge clr) begin
        if (clr) lat_q <= '0;
        else     lat_q <= lat_nxt;
      end
    end else begin : g_lat_sync
      always_ff @(posedge clk) begin
        if (clr) lat_q <= '0;
        else     lat_q <= lat_nxt;
      end
    end

    if (OUT_REG) begin : g_oreg
      logic [DATA_W-1:0] oreg_q;
      if (RST_ASYNC) begin : g_async
        always_ff @(posedge clk or posedge clr) begin
          if (clr)     oreg_q <= '0;
          else if (ce) oreg_q <= lat_q;
        end
      end else begin : g_sync
        always_ff @(posedge clk) begin
          if (clr)     oreg_q <= '0;
          else if (ce) oreg_q <= lat_q;
        end
      end
      assign dout = oreg_q;
    end else begin : g_noreg
      assign dout = lat_q;
    end
  endgenerate

endmodule

// File: rtl/tdp_block_ram.sv
// True dual-port RAM tile: two XOR-coded banks, two port controllers.
module tdp_block_ram
  import tdp_ram_pkg::*;
#(
  parameter int              ADDR_W     = 10,
  parameter int              DATA_W     = 18,
  parameter wmode_e          MODE_A     = WM_HOLD,
  parameter wmode_e          MODE_B     = WM_HOLD,
  parameter bit              OUT_REG_A  = 1'b0,
  parameter bit              OUT_REG_B  = 1'b0,
  parameter bit              RST_ASYNC  = 1'b0,
  parameter logic [CS_W-1:0] CS_MATCH_A = '0,
  parameter logic [CS_W-1:0] CS_MATCH_B = '0
) (
  input  logic              clk_a,
  input  logic              ce_a,
  input  logic              we_a,
  input  logic [CS_W-1:0]   cs_a,
  input  logic              rst_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din_a,
  output logic [DATA_W-1:0] dout_a,
  input  logic              clk_b,
  input  logic              ce_b,
  input  logic              we_b,
  input  logic [CS_W-1:0]   cs_b,
  input  logic              rst_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] dout_b,
  input  logic              gsr_n
);

  localparam int NPORT = 2;

  // Stored word = XOR of both banks at that address
  function automatic logic [DATA_W-1:0] merge_word(input logic [DATA_W-1:0] own,
                                                   input logic [DATA_W-1:0] peer);
    return own ^ peer;
  endfunction

  // Word a port writes into its own bank so that the merge yields wdata
  function automatic logic [DATA_W-1:0] encode_word(input logic [DATA_W-1:0] wdata,
                                                    input logic [DATA_W-1:0] peer);
    return wdata ^ peer;
  endfunction

  logic              clk_p   [NPORT];
  logic              ce_p    [NPORT];
  logic              we_p    [NPORT];
  logic [CS_W-1:0]   cs_p    [NPORT];
  logic              rst_p   [NPORT];
  logic [ADDR_W-1:0] addr_p  [NPORT];
  logic [DATA_W-1:0] din_p   [NPORT];
  logic [DATA_W-1:0] dout_p  [NPORT];
  logic              hit_p   [NPORT];
  logic              wr_p    [NPORT];
  logic [DATA_W-1:0] lat_p   [NPORT];
  logic [DATA_W-1:0] rdw_p   [NPORT];
  // bank_rd[bank][port]: bank contents at that port's address
  logic [DATA_W-1:0] bank_rd [NPORT][NPORT];

  assign clk_p[0]  = clk_a;   assign clk_p[1]  = clk_b;
  assign ce_p[0]   = ce_a;    assign ce_p[1]   = ce_b;
  assign we_p[0]   = we_a;    assign we_p[1]   = we_b;
  assign cs_p[0]   = cs_a;    assign cs_p[1]   = cs_b;
  assign rst_p[0]  = rst_a;   assign rst_p[1]  = rst_b;
  assign addr_p[0] = addr_a;  assign addr_p[1] = addr_b;
  assign din_p[0]  = din_a;   assign din_p[1]  = din_b;
  assign dout_a    = dout_p[0];
  assign dout_b    = dout_p[1];

  // Named internal events for the checker
  logic              act_a, act_b, wr_a, wr_b;
  logic [DATA_W-1:0] rd_word_a, rd_word_b, lat_a, lat_b;
  assign act_a     = hit_p[0];
  assign act_b     = hit_p[1];
  assign wr_a      = wr_p[0];
  assign wr_b      = wr_p[1];
  assign rd_word_a = rdw_p[0];
  assign rd_word_b = rdw_p[1];
  assign lat_a     = lat_p[0];
  assign lat_b     = lat_p[1];

  genvar g;
  generate
    for (g = 0; g < NPORT; g++) begin : g_port
      tdp_ram_bank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
      ) u_bank (
        .clk    (clk_p[g]),
        .we     (wr_p[g]),
        .waddr  (addr_p[g]),
        .wword  (encode_word(din_p[g], bank_rd[NPORT-1-g][g])),
        .raddr0 (addr_p[0]),
        .raddr1 (addr_p[1]),
        .rdata0 (bank_rd[g][0]),
        .rdata1 (bank_rd[g][1])
      );

      assign rdw_p[g] = merge_word(bank_rd[g][g], bank_rd[NPORT-1-g][g]);

      tdp_ram_port #(
        .DATA_W    (DATA_W),
        .MODE      ((g == 0) ? MODE_A : MODE_B),
        .OUT_REG   ((g == 0) ? OUT_REG_A : OUT_REG_B),
        .RST_ASYNC (RST_ASYNC),
        .CS_MATCH  ((g == 0) ? CS_MATCH_A : CS_MATCH_B)
      ) u_port (
        .clk     (clk_p[g]),
        .ce      (ce_p[g]),
        .we      (we_p[g]),
        .cs      (cs_p[g]),
        .rst     (rst_p[g]),
        .gsr_n   (gsr_n),
        .din     (din_p[g]),
        .rd_word (rdw_p[g]),
        .hit     (hit_p[g]),
        .wr_fire (wr_p[g]),
        .lat_q   (lat_p[g]),
        .dout    (dout_p[g])
      );
    end
  endgenerate

endmodule

// File: rtl/tdp_ram_checker.sv
module tdp_ram_checker
  import tdp_ram_pkg::*;
#(
  parameter int     DATA_W    = 18,
  parameter wmode_e MODE_A    = WM_HOLD,
  parameter wmode_e MODE_B    = WM_HOLD,
  parameter bit     OUT_REG_A = 1'b0,
  parameter bit     OUT_REG_B = 1'b0
) (
  input logic              clk_a,
  input logic              ce_a,
  input logic              we_a,
  input logic              rst_a,
  input logic [DATA_W-1:0] din_a,
  input logic [DATA_W-1:0] dout_a,
  input logic              act_a,
  input logic              wr_a,
  input logic [DATA_W-1:0] rd_a,
  input logic [DATA_W-1:0] lat_a,
  input logic              clk_b,
  input logic              ce_b,
  input logic              we_b,
  input logic              rst_b,
  input logic [DATA_W-1:0] din_b,
  input logic [DATA_W-1:0] dout_b,
  input logic              act_b,
  input logic              wr_b,
  input logic [DATA_W-1:0] rd_b,
  input logic [DATA_W-1:0] lat_b,
  input logic              gsr_n
);

  logic clr_a, clr_b;
  assign clr_a = rst_a || !gsr_n;
  assign clr_b = rst_b || !gsr_n;

  // Port A
  assert_read_a_R1: assert property (@(posedge clk_a) disable iff (clr_a)
    (act_a && !we_a) |=> (lat_a == $past(rd_a)));
  assert_oreg_a_R2: assert property (@(posedge clk_a) disable iff (clr_a)
    (OUT_REG_A && ce_a) |=> (dout_a == $past(lat_a)));
  assert_hold_a_R3: assert property (@(posedge clk_a) disable iff (clr_a)
    ((MODE_A == WM_HOLD) && wr_a) |=> $stable(lat_a));
  assert_pass_a_R4: assert property (@(posedge clk_a) disable iff (clr_a)
    ((MODE_A == WM_PASS) && wr_a) |=> (lat_a == $past(din_a)));
  assert_old_a_R5: assert property (@(posedge clk_a) disable iff (clr_a)
    ((MODE_A == WM_OLD) && wr_a) |=> (lat_a == $past(rd_a)));
  assert_idle_a_R6: assert property (@(posedge clk_a) disable iff (clr_a)
    !act_a |=> $stable(lat_a));
  assert_local_clear_a_R7: assert property (@(posedge clk_a) disable iff (!gsr_n)
    rst_a |=> (dout_a == '0));

  // Port B
  assert_read_b_R1: assert property (@(posedge clk_b) disable iff (clr_b)
    (act_b && !we_b) |=> (lat_b == $past(rd_b)));
  assert_oreg_b_R2: assert property (@(posedge clk_b) disable iff (clr_b)
    (OUT_REG_B && ce_b) |=> (dout_b == $past(lat_b)));
  assert_hold_b_R3: assert property (@(posedge clk_b) disable iff (clr_b)
    ((MODE_B == WM_HOLD) && wr_b) |=> $stable(lat_b));
  assert_pass_b_R4: assert property (@(posedge clk_b) disable iff (clr_b)
    ((MODE_B == WM_PASS) && wr_b) |=> (lat_b == $past(din_b)));
  assert_old_b_R5: assert property (@(posedge clk_b) disable iff (clr_b)
    ((MODE_B == WM_OLD) && wr_b) |=> (lat_b == $past(rd_b)));
  assert_idle_b_R6: assert property (@(posedge clk_b) disable iff (clr_b)
    !act_b |=> $stable(lat_b));
  assert_local_clear_b_R7: assert property (@(posedge clk_b) disable iff (!gsr_n)
    rst_b |=> (dout_b == '0));

  // Global reset clears both outputs
  assert_global_clear_R8: assert property (@(posedge clk_a)
    !gsr_n |=> ((dout_a == '0) && (dout_b == '0)));

endmodule

bind tdp_block_ram tdp_ram_checker #(
  .DATA_W    (DATA_W),
  .MODE_A    (MODE_A),
  .MODE_B    (MODE_B),
  .OUT_REG_A (OUT_REG_A),
  .OUT_REG_B (OUT_REG_B)
) i_chk (
  .clk_a  (clk_a),
  .ce_a   (ce_a),
  .we_a   (we_a),
  .rst_a  (rst_a),
  .din_a  (din_a),
  .dout_a (dout_a),
  .act_a  (act_a),
  .wr_a   (wr_a),
  .rd_a   (rd_word_a),
  .lat_a  (lat_a),
  .clk_b  (clk_b),
  .ce_b   (ce_b),
  .we_b   (we_b),
  .rst_b  (rst_b),
  .din_b  (din_b),
  .dout_b (dout_b),
  .act_b  (act_b),
  .wr_b   (wr_b),
  .rd_b   (rd_word_b),
  .lat_b  (lat_b),
  .gsr_n  (gsr_n)
);

// File: tb/test_tdp_block_ram.sv
module test_tdp_block_ram;
  import tdp_ram_pkg::*;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] CSA = 3'd5;
  localparam logic [2:0] CSB = 3'd2;
  // [copy][port]: mode 0 hold, 1 pass, 2 old; output register on/off
  localparam int MODE_T [3][2] = '{'{0, 1}, '{2, 0}, '{1, 2}};
  localparam int OREG_T [3][2] = '{'{0, 1}, '{1, 0}, '{0, 1}};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          ce_a = 0, we_a = 0, rst_a = 0, ce_b = 0, we_b = 0, rst_b = 0;
  logic          gsr_n = 0;
  logic [2:0]    cs_a = 0, cs_b = 0;
  logic [AW-1:0] addr_a = 0, addr_b = 0;
  logic [DW-1:0] din_a = 0, din_b = 0;
  logic [DW-1:0] dout_a [3];
  logic [DW-1:0] dout_b [3];

  tdp_block_ram #(.ADDR_W(AW), .DATA_W(DW), .MODE_A(WM_HOLD), .MODE_B(WM_PASS),
    .OUT_REG_A(1'b0), .OUT_REG_B(1'b1), .RST_ASYNC(1'b0),
    .CS_MATCH_A(CSA), .CS_MATCH_B(CSB)) i_tdp_block_ram (
    .clk_a(clk), .ce_a(ce_a), .we_a(we_a), .cs_a(cs_a), .rst_a(rst_a),
    .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a[0]),
    .clk_b(clk), .ce_b(ce_b), .we_b(we_b), .cs_b(cs_b), .rst_b(rst_b),
    .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b[0]), .gsr_n(gsr_n));

  tdp_block_ram #(.ADDR_W(AW), .DATA_W(DW), .MODE_A(WM_OLD), .MODE_B(WM_HOLD),
    .OUT_REG_A(1'b1), .OUT_REG_B(1'b0), .RST_ASYNC(1'b1),
    .CS_MATCH_A(CSA), .CS_MATCH_B(CSB)) i_tdp_block_ram_async (
    .clk_a(clk), .ce_a(ce_a), .we_a(we_a), .cs_a(cs_a), .rst_a(rst_a),
    .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a[1]),
    .clk_b(clk), .ce_b(ce_b), .we_b(we_b), .cs_b(cs_b), .rst_b(rst_b),
    .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b[1]), .gsr_n(gsr_n));

  tdp_block_ram #(.ADDR_W(AW), .DATA_W(DW), .MODE_A(WM_PASS), .MODE_B(WM_OLD),
    .OUT_REG_A(1'b0), .OUT_REG_B(1'b1), .RST_ASYNC(1'b0),
    .CS_MATCH_A(CSA), .CS_MATCH_B(CSB)) i_tdp_block_ram_swap (
    .clk_a(clk), .ce_a(ce_a), .we_a(we_a), .cs_a(cs_a), .rst_a(rst_a),
    .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a[2]),
    .clk_b(clk), .ce_b(ce_b), .we_b(we_b), .cs_b(cs_b), .rst_b(rst_b),
    .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b[2]), .gsr_n(gsr_n));

  // ---------------- reference model ----------------
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] m_lat [3][2];
  logic [DW-1:0] m_q   [3][2];

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    for (int i = 0; i < 3; i++)
      for (int p = 0; p < 2; p++) begin m_lat[i][p] = '0; m_q[i][p] = '0; end
  end

  always @(posedge clk) begin
    logic          sel [2];
    logic          wen [2];
    logic          cen [2];
    logic          clr [2];
    logic [DW-1:0] old [2];
    logic [DW-1:0] wd  [2];
    sel[0] = ce_a && (cs_a == CSA);   sel[1] = ce_b && (cs_b == CSB);
    wen[0] = we_a;  wen[1] = we_b;
    cen[0] = ce_a;  cen[1] = ce_b;
    clr[0] = rst_a || !gsr_n;  clr[1] = rst_b || !gsr_n;
    old[0] = ref_mem[addr_a];  old[1] = ref_mem[addr_b];
    wd[0]  = din_a;  wd[1] = din_b;
    for (int i = 0; i < 3; i++)
      for (int p = 0; p < 2; p++) begin
        if (clr[p]) begin
          m_lat[i][p] = '0; m_q[i][p] = '0;
        end else begin
          if (cen[p]) m_q[i][p] = m_lat[i][p];
          if (sel[p]) begin
            if (!wen[p])                m_lat[i][p] = old[p];
            else if (MODE_T[i][p] == 1) m_lat[i][p] = wd[p];
            else if (MODE_T[i][p] == 2) m_lat[i][p] = old[p];
          end
        end
      end
    if (sel[0] && wen[0]) ref_mem[addr_a] = din_a;
    if (sel[1] && wen[1]) ref_mem[addr_b] = din_b;
  end

  function automatic logic [DW-1:0] expd(input int i, input int p);
    return (OREG_T[i][p] != 0) ? m_q[i][p] : m_lat[i][p];
  endfunction

  function automatic logic [DW-1:0] pat_f(input int a); return DW'(a * 29 + 7);   endfunction
  function automatic logic [DW-1:0] pat_g(input int a); return ~pat_f(a);         endfunction
  function automatic logic [DW-1:0] pat_h(input int a); return DW'(a * 13 + 100); endfunction

  // ---------------- checking ----------------
  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 0;

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 3; i++) begin
      chk({tag, " port A"}, dout_a[i], expd(i, 0));
      chk({tag, " port B"}, dout_b[i], expd(i, 1));
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle_ports();
    ce_a = 0; we_a = 0; ce_b = 0; we_b = 0;
  endtask

  task automatic read_sweep(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      ce_a = 1; we_a = 0; cs_a = CSA; addr_a = AW'(a);
      ce_b = 1; we_b = 0; cs_b = CSB; addr_b = AW'(DEPTH - 1 - a);
      step(tag);
    end
  endtask

  initial begin
    #(10 * 20000);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    end
    $finish;
  end

  initial begin
    // R8: global reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R8 reset state A", dout_a[i], '0);
      chk("R8 reset state B", dout_b[i], '0);
    end
    gsr_n = 1;
    step("R8 release");

    // B fills memory: copies hold / pass / old on port B (R3, R4, R5)
    for (int a = 0; a < DEPTH; a++) begin
      ce_b = 1; we_b = 1; cs_b = CSB; addr_b = AW'(a); din_b = pat_f(a);
      step("R3,R4,R5 fill by B");
    end
    idle_ports();
    step("R6 idle");

    // Reads on both ports, output register latency (R1, R2)
    read_sweep("R1,R2 read sweep");

    // A writes while B reads a different address (R3, R4, R5, R9)
    for (int a = 0; a < DEPTH; a++) begin
      ce_a = 1; we_a = 1; cs_a = CSA; addr_a = AW'(a); din_a = pat_g(a);
      ce_b = 1; we_b = 0; cs_b = CSB; addr_b = AW'((a + 8) % DEPTH);
      step("R3,R4,R5,R9 A writes");
    end

    // B writes address that A reads in the same cycle: old word (R9)
    for (int a = 0; a < DEPTH; a++) begin
      ce_a = 1; we_a = 0; cs_a = CSA; addr_a = AW'(a);
      ce_b = 1; we_b = 1; cs_b = CSB; addr_b = AW'(a); din_b = pat_h(a);
      step("R9 same-address read/write");
    end

    // Deselected writes: wrong chip select on A, enable low on B (R6)
    for (int a = 0; a < DEPTH; a++) begin
      ce_a = 1; we_a = 1; cs_a = CSA ^ 3'd1; addr_a = AW'(a); din_a = 8'h00;
      ce_b = 0; we_b = 1; cs_b = CSB; addr_b = AW'(a); din_b = 8'hFF;
      step("R6 deselected write");
    end
    read_sweep("R6 contents kept");
    idle_ports();
    step("R6 idle");

    // Local reset on A: asynchronous copy clears mid-cycle, others wait (R7)
    rst_a = 1;
    #1;
    chk("R7 async clear A", dout_a[1], '0);
    chk("R7 sync hold A", dout_a[0], expd(0, 0));
    chk("R7 sync hold A", dout_a[2], expd(2, 0));
    for (int i = 0; i < 3; i++) chk("R7 other port untouched", dout_b[i], expd(i, 1));
    step("R7 reset A edge");
    rst_a = 0;
    step("R7 reset A release");

    // Local reset on B (R7)
    rst_b = 1;
    #1;
    chk("R7 async clear B", dout_b[1], '0);
    chk("R7 sync hold B", dout_b[0], expd(0, 1));
    chk("R7 sync hold B", dout_b[2], expd(2, 1));
    for (int i = 0; i < 3; i++) chk("R7 other port untouched", dout_a[i], expd(i, 0));
    step("R7 reset B edge");
    rst_b = 0;
    read_sweep("R7 contents kept");
    idle_ports();
    step("R8 idle");

    // Global reset (R8)
    gsr_n = 0;
    #1;
    chk("R8 async clear A", dout_a[1], '0);
    chk("R8 async clear B", dout_b[1], '0);
    chk("R8 sync hold A", dout_a[0], expd(0, 0));
    chk("R8 sync hold B", dout_b[2], expd(2, 1));
    step("R8 global edge");
    for (int i = 0; i < 3; i++) begin
      chk("R8 cleared A", dout_a[i], '0);
      chk("R8 cleared B", dout_b[i], '0);
    end
    gsr_n = 1;
    read_sweep("R8 contents kept");
    idle_ports();
    step("R2 drain");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    end
    $finish;
  end

endmodule